// File: doc/BRIEF.md
# Exception Entry Sequencer

This block does the hardware part of taking an exception on a 32-bit processor and of leaving it again. It watches event pulses for reset, software interrupt, prefetch abort and data abort, and the level-sensitive interrupt and fast-interrupt lines. When an event is accepted it issues, in the next cycle, the full set of state updates for exception entry. These are a write of the return address into the link register banked for the target mode, a write of the current status word into that mode's saved-status register, a new status word, and a new program counter taken from the vector table.

Each exception has its own target mode, return-address offset, vector offset and interrupt-mask rule. A configuration pin moves the whole vector table from address zero to a high base. A return request from the handler restores the status word from the saved copy and reloads the program counter from the link value in the same cycle. For a prefetch abort return, 4 is subtracted from the link value. The register file, the memory management unit and the handler software are outside the block.

Top module: `exc_seq`

## Requirements
- R1: Every command appears on the registered outputs exactly one clock after the inputs that caused it. In a cycle with no accepted event and no return request, all four write strobes are low in the next cycle. After the block's own reset, all strobes are low.
- R2: A reset event produces `status_we` with mode bits [4:0] = 5'b10011 and bits [7:5] = 3'b110. It also produces `pc_we` to the vector base plus 0x00. It writes neither the link register nor the saved-status register.
- R3: A software interrupt enters mode 5'b10011. It writes link = `instr_addr` + 4 and sends the PC to base + 0x08.
- R4: A prefetch abort enters mode 5'b10111. It writes link = `instr_addr` + 4 and sends the PC to base + 0x0C. The event has no effect while `pabt_cancel` is high.
- R5: A data abort enters mode 5'b10111. It writes link = `instr_addr` + 8 and sends the PC to base + 0x10.
- R6: The interrupt line enters mode 5'b10010. It writes link = `instr_addr` + 8 and sends the PC to base + 0x18. It is ignored while `cur_status` bit 7 is 1.
- R7: The fast-interrupt line enters mode 5'b10001. It writes link = `instr_addr` + 8, sends the PC to base + 0x1C and sets status bit 6. It is ignored while `cur_status` bit 6 is 1.
- R8: On every non-reset entry, `saved_data` equals `cur_status` and `bank_mode` equals the new mode bits. The new status word has bit 7 set and bit 5 cleared. Bit 6 is kept from `cur_status` except on reset and fast interrupt. Bits [31:8] are kept from `cur_status`.
- R9: Simultaneous accepted events are served in this order: reset, data abort, fast interrupt, interrupt, prefetch abort, software interrupt. Any accepted event outranks a return request.
- R10: With `high_vec` = 1, the vector base is 0xFFFF0000 instead of 0x00000000, for every exception.
- R11: A return request, when no event is accepted, sets `pc_data` = `ret_link`, or `ret_link` − 4 when `ret_sub4` = 1. In the same cycle it sets `status_data` = `ret_saved`. It raises neither banked write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| evt_reset | input | 1 | Processor reset event pulse |
| evt_swi | input | 1 | Software interrupt event pulse |
| evt_pabt | input | 1 | Prefetch abort event pulse |
| evt_dabt | input | 1 | Data abort event pulse |
| irq_line | input | 1 | Normal interrupt request level |
| fiq_line | input | 1 | Fast interrupt request level |
| pabt_cancel | input | 1 | Aborted fetch was flushed by an earlier taken branch |
| instr_addr | input | 32 | Address of the faulting or current instruction |
| cur_status | input | 32 | Current status word |
| high_vec | input | 1 | Selects the high vector base |
| ret_req | input | 1 | Return-from-exception request |
| ret_sub4 | input | 1 | Subtract 4 from the link value on return |
| ret_link | input | 32 | Banked link value read for the return |
| ret_saved | input | 32 | Saved status word read for the return |
| bank_we_link | output | 1 | Write strobe for the banked link register |
| bank_we_saved | output | 1 | Write strobe for the banked saved-status register |
| bank_mode | output | 5 | Mode whose banked registers are written |
| link_data | output | 32 | Return address to store |
| saved_data | output | 32 | Status word to store in the saved copy |
| status_we | output | 1 | Write strobe for the current status word |
| status_data | output | 32 | New current status word |
| pc_we | output | 1 | Write strobe for the program counter |
| pc_data | output | 32 | New program counter |

## Verification
Each event source is driven alone, once with the low and once with the high vector base. This separates the per-exception offset, mode and vector from the base selection. Masked and cancelled variants, an fast interrupt masked while the interrupt is open, and a status word with bits 6 and 5 already set show which rule drives each status bit. Stacked event combinations, each removing the previous winner, step through the whole priority chain. Returns with and without the 4-byte adjustment, plus a return that collides with an event, show the exit path and its rank.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int WORD_W  = 32;
    localparam int MODE_W  = 5;
    localparam int NUM_SRC = 6;

    localparam int BIT_IRQ_OFF = 7;
    localparam int BIT_FIQ_OFF = 6;
    localparam int BIT_ALT_SET = 5;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam mode_t MODE_SVC = 5'b10011;
    localparam mode_t MODE_ABT = 5'b10111;
    localparam mode_t MODE_IRQ = 5'b10010;
    localparam mode_t MODE_FIQ = 5'b10001;

    typedef enum logic [2:0] {
        EK_NONE,
        EK_RESET,
        EK_DABT,
        EK_FIQ,
        EK_IRQ,
        EK_PABT,
        EK_SWI
    } exc_kind_e;

    typedef struct packed {
        mode_t      mode;
        logic [3:0] ret_off;
        logic [7:0] vec_off;
        logic       mask_fiq;
        logic       save_state;
    } exc_profile_t;

    typedef struct packed {
        logic  save;
        mode_t bank_mode;
        word_t link;
        word_t saved;
        word_t status;
        word_t pc;
    } entry_cmd_t;

    typedef struct packed {
        word_t status;
        word_t pc;
    } return_cmd_t;

    // Priority slot 0 is served first.
    function automatic exc_kind_e kind_at(input int slot);
        case (slot)
            0:       return EK_RESET;
            1:       return EK_DABT;
            2:       return EK_FIQ;
            3:       return EK_IRQ;
            4:       return EK_PABT;
            5:       return EK_SWI;
            default: return EK_NONE;
        endcase
    endfunction

    function automatic exc_profile_t profile_of(input exc_kind_e k);
        exc_profile_t p;
        p = '0;
        case (k)
            EK_RESET: p = '{mode: MODE_SVC, ret_off: 4'd0, vec_off: 8'h00, mask_fiq: 1'b1, save_state: 1'b0};
            EK_DABT:  p = '{mode: MODE_ABT, ret_off: 4'd8, vec_off: 8'h10, mask_fiq: 1'b0, save_state: 1'b1};
            EK_FIQ:   p = '{mode: MODE_FIQ, ret_off: 4'd8, vec_off: 8'h1C, mask_fiq: 1'b1, save_state: 1'b1};
            EK_IRQ:   p = '{mode: MODE_IRQ, ret_off: 4'd8, vec_off: 8'h18, mask_fiq: 1'b0, save_state: 1'b1};
            EK_PABT:  p = '{mode: MODE_ABT, ret_off: 4'd4, vec_off: 8'h0C, mask_fiq: 1'b0, save_state: 1'b1};
            EK_SWI:   p = '{mode: MODE_SVC, ret_off: 4'd4, vec_off: 8'h08, mask_fiq: 1'b0, save_state: 1'b1};
            default:  p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_seq_pkg::*;
(
    input  logic      evt_reset,
    input  logic      evt_swi,
    input  logic      evt_pabt,
    input  logic      evt_dabt,
    input  logic      irq_line,
    input  logic      fiq_line,
    input  logic      pabt_cancel,
    input  logic      irq_masked,
    input  logic      fiq_masked,
    output exc_kind_e kind
);

    logic [NUM_SRC-1:0] live;

    always_comb begin
        live    = '0;
        live[0] = evt_reset;
        live[1] = evt_dabt;
        live[2] = fiq_line & ~fiq_masked;
        live[3] = irq_line & ~irq_masked;
        live[4] = evt_pabt & ~pabt_cancel;
        live[5] = evt_swi;
    end

    // Scan from the lowest rank upward so the highest-ranked live source wins.
    always_comb begin
        kind = EK_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (live[i]) kind = kind_at(i);
        end
    end

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
    import exc_seq_pkg::*;
#(
    parameter word_t LOW_BASE  = 32'h0000_0000,
    parameter word_t HIGH_BASE = 32'hFFFF_0000
)(
    input  exc_kind_e  kind,
    input  word_t      instr_addr,
    input  word_t      cur_status,
    input  logic       high_vec,
    output entry_cmd_t cmd
);

    exc_profile_t prof;
    word_t        next_status;
    word_t        base;

    always_comb begin
        prof = profile_of(kind);
        base = high_vec ? HIGH_BASE : LOW_BASE;

        next_status                = cur_status;
        next_status[MODE_W-1:0]    = prof.mode;
        next_status[BIT_IRQ_OFF]   = 1'b1;
        next_status[BIT_ALT_SET]   = 1'b0;
        if (prof.mask_fiq) next_status[BIT_FIQ_OFF] = 1'b1;

        cmd.save      = prof.save_state && (kind != EK_NONE);
        cmd.bank_mode = prof.mode;
        cmd.link      = instr_addr + word_t'(prof.ret_off);
        cmd.saved     = cur_status;
        cmd.status    = next_status;
        cmd.pc        = base | word_t'(prof.vec_off);
    end

endmodule

// File: rtl/exc_return_calc.sv
module exc_return_calc
    import exc_seq_pkg::*;
#(
    parameter int ADJ_BYTES = 4
)(
    input  word_t       ret_link,
    input  word_t       ret_saved,
    input  logic        ret_sub4,
    output return_cmd_t cmd
);

    localparam word_t ADJ = word_t'(ADJ_BYTES);

    always_comb begin
        cmd.pc     = ret_sub4 ? (ret_link - ADJ) : ret_link;
        cmd.status = ret_saved;
    end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_seq_pkg::*;
#(
    parameter logic [31:0] LOW_BASE  = 32'h0000_0000,
    parameter logic [31:0] HIGH_BASE = 32'hFFFF_0000
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        evt_reset,
    input  logic        evt_swi,
    input  logic        evt_pabt,
    input  logic        evt_dabt,
    input  logic        irq_line,
    input  logic        fiq_line,
    input  logic        pabt_cancel,
    input  logic [31:0] instr_addr,
    input  logic [31:0] cur_status,
    input  logic        high_vec,
    input  logic        ret_req,
    input  logic        ret_sub4,
    input  logic [31:0] ret_link,
    input  logic [31:0] ret_saved,
    output logic        bank_we_link,
    output logic        bank_we_saved,
    output logic [4:0]  bank_mode,
    output logic [31:0] link_data,
    output logic [31:0] saved_data,
    output logic        status_we,
    output logic [31:0] status_data,
    output logic        pc_we,
    output logic [31:0] pc_data
);

    exc_kind_e   arb_kind;
    entry_cmd_t  ent;
    return_cmd_t rtn;

    exc_arbiter u_arb (
        .evt_reset   (evt_reset),
        .evt_swi     (evt_swi),
        .evt_pabt    (evt_pabt),
        .evt_dabt    (evt_dabt),
        .irq_line    (irq_line),
        .fiq_line    (fiq_line),
        .pabt_cancel (pabt_cancel),
        .irq_masked  (cur_status[BIT_IRQ_OFF]),
        .fiq_masked  (cur_status[BIT_FIQ_OFF]),
        .kind        (arb_kind)
    );

    exc_entry_calc #(
        .LOW_BASE  (LOW_BASE),
        .HIGH_BASE (HIGH_BASE)
    ) u_entry (
        .kind       (arb_kind),
        .instr_addr (instr_addr),
        .cur_status (cur_status),
        .high_vec   (high_vec),
        .cmd        (ent)
    );

    exc_return_calc #(
        .ADJ_BYTES (4)
    ) u_ret (
        .ret_link  (ret_link),
        .ret_saved (ret_saved),
        .ret_sub4  (ret_sub4),
        .cmd       (rtn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_we_link  <= 1'b0;
            bank_we_saved <= 1'b0;
            bank_mode     <= '0;
            link_data     <= '0;
            saved_data    <= '0;
            status_we     <= 1'b0;
            status_data   <= '0;
            pc_we         <= 1'b0;
            pc_data       <= '0;
        end else if (arb_kind != EK_NONE) begin
            bank_we_link  <= ent.save;
            bank_we_saved <= ent.save;
            bank_mode     <= ent.bank_mode;
            link_data     <= ent.link;
            saved_data    <= ent.saved;
            status_we     <= 1'b1;
            status_data   <= ent.status;
            pc_we         <= 1'b1;
            pc_data       <= ent.pc;
        end else if (ret_req) begin
            bank_we_link  <= 1'b0;
            bank_we_saved <= 1'b0;
            status_we     <= 1'b1;
            status_data   <= rtn.status;
            pc_we         <= 1'b1;
            pc_data       <= rtn.pc;
        end else begin
            bank_we_link  <= 1'b0;
            bank_we_saved <= 1'b0;
            status_we     <= 1'b0;
            pc_we         <= 1'b0;
        end
    end

    // R1: nothing requested means no write command one cycle later
    a_r1_quiet: assert property (@(posedge clk) disable iff (rst)
        (arb_kind == EK_NONE && !ret_req) |=> (!status_we && !pc_we && !bank_we_link && !bank_we_saved));

    // R2: reset event lands in supervisor mode with both masks set, no banked writes
    a_r2_reset_entry: assert property (@(posedge clk) disable iff (rst)
        evt_reset |=> (status_data[4:0] == 5'b10011 && status_data[7:5] == 3'b110
                       && !bank_we_link && !bank_we_saved));

    // R8: every saving entry masks interrupts and clears the alternate-set bit
    a_r8_entry_bits: assert property (@(posedge clk) disable iff (rst)
        (status_we && bank_we_link) |-> (status_data[7] && !status_data[5]
                                         && status_data[4:0] == bank_mode));

    // R11: the PC and the status word always change in the same step
    a_r11_same_step: assert property (@(posedge clk) disable iff (rst)
        pc_we |-> status_we);

    // R10: vectors only come from the two table bases
    a_r10_vec_base: assert property (@(posedge clk) disable iff (rst)
        (pc_we && bank_we_saved) |-> (pc_data[31:8] == HIGH_BASE[31:8] || pc_data[31:8] == LOW_BASE[31:8]));

endmodule

// File: tb/exc_seq_test.sv
module exc_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_reset = 0, evt_swi = 0, evt_pabt = 0, evt_dabt = 0;
    logic        irq_line = 0, fiq_line = 0, pabt_cancel = 0;
    logic [31:0] instr_addr = 0, cur_status = 0;
    logic        high_vec = 0, ret_req = 0, ret_sub4 = 0;
    logic [31:0] ret_link = 0, ret_saved = 0;
    logic        bank_we_link, bank_we_saved, status_we, pc_we;
    logic [4:0]  bank_mode;
    logic [31:0] link_data, saved_data, status_data, pc_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    exc_seq uut (
        .clk(clk), .rst(rst),
        .evt_reset(evt_reset), .evt_swi(evt_swi), .evt_pabt(evt_pabt), .evt_dabt(evt_dabt),
        .irq_line(irq_line), .fiq_line(fiq_line), .pabt_cancel(pabt_cancel),
        .instr_addr(instr_addr), .cur_status(cur_status), .high_vec(high_vec),
        .ret_req(ret_req), .ret_sub4(ret_sub4), .ret_link(ret_link), .ret_saved(ret_saved),
        .bank_we_link(bank_we_link), .bank_we_saved(bank_we_saved), .bank_mode(bank_mode),
        .link_data(link_data), .saved_data(saved_data), .status_we(status_we),
        .status_data(status_data), .pc_we(pc_we), .pc_data(pc_data)
    );

    // expected values from the behavioural model
    logic        x_bank, x_st, x_pc;
    logic [4:0]  x_mode;
    logic [31:0] x_link, x_saved, x_status, x_pc_val;

    task automatic model();
        int kind;   // 0 none, 1 reset, 2 dabt, 3 fiq, 4 irq, 5 pabt, 6 swi, 7 return
        int off;
        int vec;
        logic [4:0] m;
        logic [31:0] s;
        if (evt_reset)                          kind = 1;
        else if (evt_dabt)                      kind = 2;
        else if (fiq_line && !cur_status[6])    kind = 3;
        else if (irq_line && !cur_status[7])    kind = 4;
        else if (evt_pabt && !pabt_cancel)      kind = 5;
        else if (evt_swi)                       kind = 6;
        else if (ret_req)                       kind = 7;
        else                                    kind = 0;
        x_bank = 0; x_st = 0; x_pc = 0;
        x_mode = 0; x_link = 0; x_saved = 0; x_status = 0; x_pc_val = 0;
        off = 0; vec = 0; m = 0;
        case (kind)
            1: begin m = 5'b10011; off = 0; vec = 'h00; end
            2: begin m = 5'b10111; off = 8; vec = 'h10; end
            3: begin m = 5'b10001; off = 8; vec = 'h1C; end
            4: begin m = 5'b10010; off = 8; vec = 'h18; end
            5: begin m = 5'b10111; off = 4; vec = 'h0C; end
            6: begin m = 5'b10011; off = 4; vec = 'h08; end
            default: ;
        endcase
        if (kind >= 1 && kind <= 6) begin
            s = cur_status;
            s[4:0] = m;
            s[7] = 1'b1;
            s[5] = 1'b0;
            if (kind == 1 || kind == 3) s[6] = 1'b1;
            x_st = 1; x_pc = 1; x_status = s;
            x_pc_val = (high_vec ? 32'hFFFF_0000 : 32'h0) + 32'(vec);
            x_bank = (kind != 1);
            x_mode = m; x_link = instr_addr + 32'(off); x_saved = cur_status;
        end else if (kind == 7) begin
            x_st = 1; x_pc = 1; x_status = ret_saved;
            x_pc_val = ret_sub4 ? ret_link - 32'd4 : ret_link;
        end
    endtask

    task automatic compare(input string tag);
        logic ok;
        ok = (bank_we_link === x_bank) && (bank_we_saved === x_bank)
          && (status_we === x_st) && (pc_we === x_pc);
        if (x_bank) ok = ok && (bank_mode === x_mode) && (link_data === x_link) && (saved_data === x_saved);
        if (x_st)   ok = ok && (status_data === x_status);
        if (x_pc)   ok = ok && (pc_data === x_pc_val);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got we=%b%b%b%b mode=%h link=%h saved=%h st=%h pc=%h exp we=%b%b%b%b mode=%h link=%h saved=%h st=%h pc=%h",
                tag, bank_we_link, bank_we_saved, status_we, pc_we, bank_mode, link_data, saved_data,
                status_data, pc_data, x_bank, x_bank, x_st, x_pc, x_mode, x_link, x_saved, x_status, x_pc_val);
        end
    endtask

    // inputs are set at a falling edge, the result is checked one full cycle later
    task automatic step(input string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        evt_reset = 0; evt_swi = 0; evt_pabt = 0; evt_dabt = 0;
        irq_line = 0; fiq_line = 0; pabt_cancel = 0; ret_req = 0; ret_sub4 = 0;
        high_vec = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        x_bank = 0; x_st = 0; x_pc = 0;
        compare("R1 after block reset");

        cur_status = 32'hA000_0010; instr_addr = 32'h0000_8000;
        step("R1 idle");

        evt_reset = 1;                 step("R2 reset low base");
        evt_reset = 1; high_vec = 1;   step("R2 R10 reset high base");

        evt_swi = 1;                   step("R3 swi");
        evt_swi = 1; high_vec = 1;     step("R3 R10 swi high base");

        instr_addr = 32'h0000_1234;
        evt_pabt = 1;                  step("R4 prefetch abort");
        evt_pabt = 1; pabt_cancel = 1; step("R4 cancelled abort ignored");

        evt_dabt = 1;                  step("R5 data abort");
        evt_dabt = 1; high_vec = 1;    step("R5 R10 data abort high base");

        irq_line = 1;                  step("R6 irq");
        cur_status = 32'h0000_0090;
        irq_line = 1;                  step("R6 irq masked ignored");

        cur_status = 32'h0000_0010;
        fiq_line = 1;                  step("R7 fiq");
        fiq_line = 1; high_vec = 1;    step("R7 R10 fiq high base");
        cur_status = 32'h0000_0050;
        fiq_line = 1;                  step("R7 fiq masked ignored");
        fiq_line = 1; irq_line = 1;    step("R7 R9 masked fiq lets irq through");

        cur_status = 32'h5F00_0070; instr_addr = 32'hDEAD_BEE0;
        evt_swi = 1;                   step("R8 bit6 kept bit5 cleared");
        cur_status = 32'h0000_0030;
        fiq_line = 1;                  step("R8 fiq sets bit6");

        cur_status = 32'h0000_0010; instr_addr = 32'h0000_4000;
        evt_reset = 1; evt_dabt = 1; fiq_line = 1; irq_line = 1; evt_pabt = 1; evt_swi = 1;
        step("R9 reset wins");
        evt_dabt = 1; fiq_line = 1; irq_line = 1; evt_pabt = 1; evt_swi = 1;
        step("R9 data abort wins");
        fiq_line = 1; irq_line = 1; evt_pabt = 1; evt_swi = 1;
        step("R9 fiq wins");
        irq_line = 1; evt_pabt = 1; evt_swi = 1;
        step("R9 irq wins");
        evt_pabt = 1; evt_swi = 1;
        step("R9 prefetch abort wins");

        ret_req = 1; ret_link = 32'h0000_2004; ret_saved = 32'h2000_0010;
        step("R11 return plain");
        ret_req = 1; ret_sub4 = 1; ret_link = 32'h0000_3008; ret_saved = 32'h8000_00D0;
        step("R11 return minus 4");
        ret_req = 1; evt_swi = 1;
        step("R11 R9 event beats return");
        step("R1 idle after return");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule